// File: doc/BRIEF.md
# Latched Interrupt, Status and Mask Controller

This block sits between a charger-emulation state machine and a serial register slave. Each clock it samples six live condition lines: a charging-port device present, the port handshake skipped, a connection check running, a USB data session active, a remote wake-up pending, and a supply-cycle (toggle) in progress. It shows them as a live STATUS byte. It also turns their edges into sticky bits of an INT byte, which stay set until software reads INT.

A MASK byte chooses which sticky bits may raise the shared output pin. A mask bit of 1 lets its bit through. A global enable gates the whole interrupt. The pin is shared: a select input routes either the interrupt or an external power-enable level to it. A polarity input sets whether the pin is active-high or active-low. Reads return INT, STATUS and MASK at the same time. A read strobe marks each INT read, and a write strobe loads MASK.

Top module: `irqLatchTop`

## Requirements
- R1: While reset is asserted, INT, STATUS and MASK all read 0x00.
- R2: One clock after a sample, STATUS shows the sampled lines in this layout: bit 7 device present, bit 6 handshake skipped, bit 5 connection check, bit 3 data session, bit 2 wake-up pending, bit 0 set when no toggle is in progress. Bits 4 and 1 always read 0.
- R3: A rising edge on any of the first five lines sets its INT bit (same positions as STATUS). The bit stays set after the line falls, until INT is read.
- R4: INT bit 1 is set when a toggle starts (busy line rises), and INT bit 0 is set when a toggle ends (busy line falls).
- R5: A clock with the INT read strobe high clears every INT bit.
- R6: If an event arrives in the same clock as an INT read, its bit is set after that clock and is not cleared.
- R7: A MASK write takes effect on the next clock. Bit 4 is reserved and always reads 0.
- R8: The interrupt is active while some INT bit and its MASK bit are both 1 and the global enable is 1. An event latched while masked raises the interrupt once its mask bit is written to 1.
- R9: With the global enable at 0, the interrupt stays inactive whatever INT and MASK hold.
- R10: When the select input is 1, the pin carries the power-enable level instead of the interrupt. When the polarity input is 1, the pin is high when its source is active; when it is 0, the pin is low when its source is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cdpDevice | input | 1 | Charging-port device present |
| cdpBypass | input | 1 | Port handshake skipped |
| cdpConnect | input | 1 | Connection check running |
| usbSession | input | 1 | USB data session active |
| wakePending | input | 1 | Remote wake-up pending |
| toggleBusy | input | 1 | Supply toggle in progress |
| powerEnable | input | 1 | Power-enable level for the shared pin |
| irqEnable | input | 1 | Global interrupt enable |
| pinSelPower | input | 1 | 1 = pin carries power enable, 0 = interrupt |
| pinActiveHigh | input | 1 | 1 = active-high pin, 0 = active-low |
| wrData | input | 8 | Write data for MASK |
| maskWrEn | input | 1 | MASK write strobe |
| intRdStb | input | 1 | INT read strobe (clear on read) |
| intRdData | output | 8 | INT byte |
| statusRdData | output | 8 | STATUS byte |
| maskRdData | output | 8 | MASK byte |
| pinLevel | output | 1 | Logic level of the shared open-drain pin |

## Verification
The vector walk drives each condition line on its own and in groups. This separates a level-following STATUS from an edge-latched INT: a line held high must set its INT bit only once, and that bit must survive the line falling. The busy line is toggled both ways to tell the start event from the stop event, and to check that STATUS bit 0 is inverted. Reads are issued both with no new events and together with a toggle-stop event, which shows whether clear or set takes priority. Directed cases then set the mask after an event is already latched, drop the global enable, and step through select and polarity, so that each pin-path input is seen changing the pin alone.

// File: rtl/irqPkg.sv
package irqPkg;
  localparam int REG_W    = 8;
  localparam int NUM_COND = 6;

  // condition vector index
  localparam int C_CDP  = 5;
  localparam int C_BYP  = 4;
  localparam int C_CON  = 3;
  localparam int C_USB  = 2;
  localparam int C_WAKE = 1;
  localparam int C_BUSY = 0;

  // register bit positions (decoded by software)
  localparam int B_CDP    = 7;
  localparam int B_BYP    = 6;
  localparam int B_CON    = 5;
  localparam int B_RSV    = 4;
  localparam int B_USB    = 3;
  localparam int B_WAKE   = 2;
  localparam int B_TSTART = 1;
  localparam int B_TSTOP  = 0;

  localparam logic [REG_W-1:0] MASK_WRITABLE = ~(REG_W'(1) << B_RSV);

  typedef struct packed {
    logic [REG_W-1:0] setVec;
    logic             clrInt;
    logic             maskWr;
  } irqStrobe_t;
endpackage

// File: rtl/irqCtrl.sv
module irqCtrl
  import irqPkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_COND-1:0] cond,
  input  logic                intRdStb,
  input  logic                maskWrEn,
  input  logic                irqActive,
  input  logic                powerEnable,
  input  logic                pinSelPower,
  input  logic                pinActiveHigh,
  output irqStrobe_t          strobe,
  output logic                pinLevel
);
  logic [NUM_COND-1:0] prevCond;
  logic [NUM_COND-1:0] riseVec;
  logic                busyFall;
  logic                pinSource;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevCond <= '0;
    else       prevCond <= cond;
  end

  assign riseVec  = cond & ~prevCond;
  assign busyFall = prevCond[C_BUSY] & ~cond[C_BUSY];

  always_comb begin
    strobe                  = '0;
    strobe.setVec[B_CDP]    = riseVec[C_CDP];
    strobe.setVec[B_BYP]    = riseVec[C_BYP];
    strobe.setVec[B_CON]    = riseVec[C_CON];
    strobe.setVec[B_USB]    = riseVec[C_USB];
    strobe.setVec[B_WAKE]   = riseVec[C_WAKE];
    strobe.setVec[B_TSTART] = riseVec[C_BUSY];
    strobe.setVec[B_TSTOP]  = busyFall;
    strobe.clrInt           = intRdStb;
    strobe.maskWr           = maskWrEn;
  end

  assign pinSource = pinSelPower ? powerEnable : irqActive;
  assign pinLevel  = pinActiveHigh ? pinSource : ~pinSource;
endmodule

// File: rtl/irqDatapath.sv
module irqDatapath
  import irqPkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  irqStrobe_t          strobe,
  input  logic [NUM_COND-1:0] cond,
  input  logic [REG_W-1:0]    wrData,
  input  logic                irqEnable,
  output logic [REG_W-1:0]    intQ,
  output logic [REG_W-1:0]    statusQ,
  output logic [REG_W-1:0]    maskQ,
  output logic                irqActive
);
  logic [REG_W-1:0] statusNext;
  logic [REG_W-1:0] intNext;

  always_comb begin
    statusNext          = '0;
    statusNext[B_CDP]   = cond[C_CDP];
    statusNext[B_BYP]   = cond[C_BYP];
    statusNext[B_CON]   = cond[C_CON];
    statusNext[B_USB]   = cond[C_USB];
    statusNext[B_WAKE]  = cond[C_WAKE];
    statusNext[B_TSTOP] = ~cond[C_BUSY];
  end

  // set wins over clear-on-read
  assign intNext = (strobe.clrInt ? '0 : intQ) | strobe.setVec;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      intQ    <= '0;
      statusQ <= '0;
      maskQ   <= '0;
    end else begin
      intQ    <= intNext;
      statusQ <= statusNext;
      if (strobe.maskWr) maskQ <= wrData & MASK_WRITABLE;
    end
  end

  assign irqActive = irqEnable & (|(intQ & maskQ));
endmodule

// File: rtl/irqLatchTop.sv
module irqLatchTop
  import irqPkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             cdpDevice,
  input  logic             cdpBypass,
  input  logic             cdpConnect,
  input  logic             usbSession,
  input  logic             wakePending,
  input  logic             toggleBusy,
  input  logic             powerEnable,
  input  logic             irqEnable,
  input  logic             pinSelPower,
  input  logic             pinActiveHigh,
  input  logic [REG_W-1:0] wrData,
  input  logic             maskWrEn,
  input  logic             intRdStb,
  output logic [REG_W-1:0] intRdData,
  output logic [REG_W-1:0] statusRdData,
  output logic [REG_W-1:0] maskRdData,
  output logic             pinLevel
);
  logic [NUM_COND-1:0] condVec;
  irqStrobe_t          strobe;
  logic                irqActive;

  assign condVec = {cdpDevice, cdpBypass, cdpConnect, usbSession, wakePending, toggleBusy};

  irqCtrl ctrl_i (
    .clk(clk), .rstN(rstN), .cond(condVec), .intRdStb(intRdStb),
    .maskWrEn(maskWrEn), .irqActive(irqActive), .powerEnable(powerEnable),
    .pinSelPower(pinSelPower), .pinActiveHigh(pinActiveHigh),
    .strobe(strobe), .pinLevel(pinLevel)
  );

  irqDatapath dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .cond(condVec), .wrData(wrData),
    .irqEnable(irqEnable), .intQ(intRdData), .statusQ(statusRdData),
    .maskQ(maskRdData), .irqActive(irqActive)
  );
endmodule

// File: rtl/irqLatchChk.sv
module irqLatchChk (
  input logic       clk,
  input logic       rstN,
  input logic       cdpDevice,
  input logic       cdpBypass,
  input logic       cdpConnect,
  input logic       usbSession,
  input logic       wakePending,
  input logic       toggleBusy,
  input logic       irqEnable,
  input logic       pinSelPower,
  input logic       pinActiveHigh,
  input logic [7:0] wrData,
  input logic       maskWrEn,
  input logic       intRdStb,
  input logic [7:0] intRdData,
  input logic [7:0] statusRdData,
  input logic [7:0] maskRdData,
  input logic       pinLevel
);
  logic validQ;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) validQ <= 1'b0;
    else       validQ <= 1'b1;
  end

  assert_status_R2: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> statusRdData == {$past(cdpDevice), $past(cdpBypass), $past(cdpConnect), 1'b0,
                              $past(usbSession), $past(wakePending), 1'b0, ~$past(toggleBusy)});

  assert_sticky_R3: assert property (@(posedge clk) disable iff (!rstN)
    !intRdStb |=> (intRdData & $past(intRdData)) == $past(intRdData));

  assert_stop_R4: assert property (@(posedge clk) disable iff (!rstN)
    (validQ && $fell(toggleBusy)) |=> intRdData[0]);

  assert_clear_R5: assert property (@(posedge clk) disable iff (!rstN)
    (intRdStb && !cdpDevice && !cdpBypass && !cdpConnect && !usbSession &&
     !wakePending && !toggleBusy && statusRdData == 8'h01) |=> intRdData == 8'h00);

  assert_mask_R7: assert property (@(posedge clk) disable iff (!rstN)
    maskWrEn |=> maskRdData == ($past(wrData) & 8'hEF));

  assert_gate_R9: assert property (@(posedge clk) disable iff (!rstN)
    (!irqEnable && !pinSelPower) |-> pinLevel == !pinActiveHigh);
endmodule

bind irqLatchTop irqLatchChk chk_i (
  .clk(clk), .rstN(rstN), .cdpDevice(cdpDevice), .cdpBypass(cdpBypass),
  .cdpConnect(cdpConnect), .usbSession(usbSession), .wakePending(wakePending),
  .toggleBusy(toggleBusy), .irqEnable(irqEnable), .pinSelPower(pinSelPower),
  .pinActiveHigh(pinActiveHigh), .wrData(wrData), .maskWrEn(maskWrEn),
  .intRdStb(intRdStb), .intRdData(intRdData), .statusRdData(statusRdData),
  .maskRdData(maskRdData), .pinLevel(pinLevel)
);

// File: tb/irqLatchTop_tb.sv
module irqLatchTop_tb_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [5:0] cond = '0;
  logic       powerEnable = 1'b0;
  logic       irqEnable = 1'b0;
  logic       pinSelPower = 1'b0;
  logic       pinActiveHigh = 1'b1;
  logic [7:0] wrData = '0;
  logic       maskWrEn = 1'b0;
  logic       intRdStb = 1'b0;
  logic [7:0] intRdData, statusRdData, maskRdData;
  logic       pinLevel;
  int testCnt = 0;
  int failCnt = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  irqLatchTop dut_i (
    .clk(clk), .rstN(rstN), .cdpDevice(cond[5]), .cdpBypass(cond[4]),
    .cdpConnect(cond[3]), .usbSession(cond[2]), .wakePending(cond[1]),
    .toggleBusy(cond[0]), .powerEnable(powerEnable), .irqEnable(irqEnable),
    .pinSelPower(pinSelPower), .pinActiveHigh(pinActiveHigh), .wrData(wrData),
    .maskWrEn(maskWrEn), .intRdStb(intRdStb), .intRdData(intRdData),
    .statusRdData(statusRdData), .maskRdData(maskRdData), .pinLevel(pinLevel)
  );

  // {cond[5:0] = cdp,byp,con,usb,wake,busy ; read ; expected INT ; expected STATUS}
  localparam logic [22:0] VEC [10] = '{
    {6'b000000, 1'b0, 8'h00, 8'h01},
    {6'b100000, 1'b0, 8'h80, 8'h81},
    {6'b000010, 1'b0, 8'h84, 8'h05},
    {6'b000011, 1'b0, 8'h86, 8'h04},
    {6'b000010, 1'b1, 8'h01, 8'h05},
    {6'b000000, 1'b1, 8'h00, 8'h01},
    {6'b011100, 1'b0, 8'h68, 8'h69},
    {6'b011100, 1'b0, 8'h68, 8'h69},
    {6'b000000, 1'b0, 8'h68, 8'h01},
    {6'b000000, 1'b1, 8'h00, 8'h01}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    testCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      testCnt++;
      failCnt++;
      $display("FAIL watchdog actual=running expected=done");
      finishRun();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 int", intRdData, 8'h00);
    chk("R1 status", statusRdData, 8'h00);
    chk("R1 mask", maskRdData, 8'h00);
    rstN = 1'b1;

    for (int i = 0; i < 10; i++) begin
      string tag;
      cond     = VEC[i][22:17];
      intRdStb = VEC[i][16];
      @(negedge clk);
      if (i == 4)      tag = "R6";
      else if (i == 3) tag = "R4";
      else if (VEC[i][16]) tag = "R5";
      else             tag = "R3";
      chk(tag, intRdData, VEC[i][15:8]);
      chk("R2", statusRdData, VEC[i][7:0]);
    end
    intRdStb = 1'b0;

    // R7 mask write, reserved bit
    wrData = 8'hFF; maskWrEn = 1'b1;
    @(negedge clk);
    maskWrEn = 1'b0;
    chk("R7", maskRdData, 8'hEF);
    wrData = 8'h00; maskWrEn = 1'b1;
    @(negedge clk);
    maskWrEn = 1'b0;
    chk("R7 clear", maskRdData, 8'h00);

    // R8 event latched while masked
    irqEnable = 1'b1; pinSelPower = 1'b0; pinActiveHigh = 1'b1;
    cond = 6'b100000;
    @(negedge clk);
    chk("R8 latched", intRdData, 8'h80);
    chk("R8 masked pin", {7'b0, pinLevel}, 8'h00);
    wrData = 8'h80; maskWrEn = 1'b1;
    @(negedge clk);
    maskWrEn = 1'b0;
    chk("R8 unmasked pin", {7'b0, pinLevel}, 8'h01);

    // R9 global enable
    irqEnable = 1'b0;
    #1 chk("R9", {7'b0, pinLevel}, 8'h00);
    pinActiveHigh = 1'b0;
    #1 chk("R9 low-active idle", {7'b0, pinLevel}, 8'h01);
    irqEnable = 1'b1;
    #1 chk("R10 low-active asserted", {7'b0, pinLevel}, 8'h00);

    // R10 function select
    pinSelPower = 1'b1; pinActiveHigh = 1'b1; powerEnable = 1'b1;
    #1 chk("R10 power high", {7'b0, pinLevel}, 8'h01);
    powerEnable = 1'b0;
    #1 chk("R10 power off ignores irq", {7'b0, pinLevel}, 8'h00);
    pinActiveHigh = 1'b0;
    #1 chk("R10 power off low-active", {7'b0, pinLevel}, 8'h01);

    done = 1'b1;
    finishRun();
  end
endmodule